// File: doc/BRIEF.md
# PHY Management Register Access Unit

This block gives software two 32-bit registers, a command register and a data register, for reading and writing the 16-bit registers of one attached Ethernet PHY. Software first loads the data register when it intends a write. It then writes the command register with a 5-bit PHY register index and a read or write request bit. The unit holds the command pending for a fixed number of cycles and then performs the access. For a write, the low half of the data register goes to the PHY. For a read, the PHY value lands in the high half of the data register. The request bit then clears, and software polls for that.

The PHY side is a compact behavioural register file. It models reset values, per-register write masks, instant autonegotiation completion, an interrupt-source register that clears when read, and link-state tracking driven by an input pin. With this model the unit can be verified without any real PHY. Serial management timing and multiple PHY addresses are not modelled.

Top module: `phy_mgmt_unit`

## Requirements
- R1: After reset, `ctrl_q` and `data_q` read zero and no command is pending.
- R2: A command-register write made while idle is stored whole. Its index sits in bits 25:21, bit 27 requests a write and bit 26 requests a read. A command with bit 26 or bit 27 set stays pending for exactly CMD_LATENCY cycles, and then both bits clear.
- R3: While a command is pending, bus writes to either register are ignored.
- R4: A completed read places the PHY value in `data_q[31:16]` and leaves `data_q[15:0]` unchanged.
- R5: After PHY reset: status (index 1) is 0x7809, control (index 0) is 0x3000, advertisement (index 4) is 0x01E1, and the interrupt mask (index 30) is 0.
- R6: A write to control with bit 15 set resets the PHY. Without bit 15, control stores the value ANDed with 0x7980, and if bit 12 is set, status bit 5 is set.
- R7: A write to advertisement stores the value ANDed with 0x2D7F, with bit 7 forced to 1.
- R8: Index 2 reads 0x0007, index 3 reads 0xC0D1, index 5 reads 0x0F71 and index 6 reads 0x0001. Status is read-only. Any other index reads zero and ignores writes.
- R9: Index 29 returns the interrupt sources and clears them on read. Index 30 keeps only the low 8 bits of a write.
- R10: When the link comes up (also right after any PHY reset), status bits 2 and 5 are set and interrupt sources bit 7 and bit 6 are raised. When the link goes down, those status bits clear and source bit 4 is raised.
- R11: When bits 26 and 27 are both set, the access is a write, and `data_q` is not changed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_sel | input | 1 | Register select: 0 command, 1 data |
| bus_wdata | input | 32 | Register write data |
| link_up | input | 1 | Current PHY link state |
| ctrl_q | output | 32 | Command register contents |
| data_q | output | 32 | Data register contents |

## Verification
The embedded assertions check, on every cycle, the following properties:
- a pending command completes after its countdown;
- both registers hold still while a command is pending;
- a read never disturbs the low data half;
- the stored control and advertisement values always respect their masks;
- a read of the interrupt sources empties them;
- a link event leaves the status bits in the matching state.

Only the bench scenarios can show the data-dependent results. These are the reset and identity values returned through the data register, the autonegotiation side effect, the ordering of link events against clear-on-read, and the re-application of link state after a software-triggered PHY reset.

// File: rtl/phy_mgmt_pkg.sv
package phy_mgmt_pkg;
  localparam int REG_W   = 32;
  localparam int PHY_W   = 16;
  localparam int IDX_W   = 5;
  localparam int ISRC_W  = 8;

  // command register field positions
  localparam int IDX_LSB = 21;
  localparam int RD_BIT  = 26;
  localparam int WR_BIT  = 27;

  // PHY register indices
  localparam logic [IDX_W-1:0] IX_CTRL = 5'd0;
  localparam logic [IDX_W-1:0] IX_STAT = 5'd1;
  localparam logic [IDX_W-1:0] IX_IDH  = 5'd2;
  localparam logic [IDX_W-1:0] IX_IDL  = 5'd3;
  localparam logic [IDX_W-1:0] IX_ADV  = 5'd4;
  localparam logic [IDX_W-1:0] IX_LPA  = 5'd5;
  localparam logic [IDX_W-1:0] IX_EXP  = 5'd6;
  localparam logic [IDX_W-1:0] IX_ISRC = 5'd29;
  localparam logic [IDX_W-1:0] IX_IMSK = 5'd30;

  // reset values and fixed contents
  localparam logic [PHY_W-1:0] STAT_RST = 16'h7809;
  localparam logic [PHY_W-1:0] CTRL_RST = 16'h3000;
  localparam logic [PHY_W-1:0] ADV_RST  = 16'h01E1;
  localparam logic [PHY_W-1:0] ID_HI    = 16'h0007;
  localparam logic [PHY_W-1:0] ID_LO    = 16'hC0D1;
  localparam logic [PHY_W-1:0] LPA_VAL  = 16'h0F71;
  localparam logic [PHY_W-1:0] EXP_VAL  = 16'h0001;

  // write masks and control bits
  localparam logic [PHY_W-1:0] CTRL_WMASK = 16'h7980;
  localparam logic [PHY_W-1:0] ADV_WMASK  = 16'h2D7F;
  localparam logic [PHY_W-1:0] ADV_FORCE  = 16'h0080;
  localparam int SOFT_RST_BIT = 15;
  localparam int AN_START_BIT = 12;
  localparam logic [PHY_W-1:0] AN_DONE   = 16'h0020;
  localparam logic [PHY_W-1:0] LINK_STAT = 16'h0024;

  // interrupt source bits
  localparam logic [ISRC_W-1:0] SRC_UP   = 8'hC0;
  localparam logic [ISRC_W-1:0] SRC_DOWN = 8'h10;
endpackage

// File: rtl/phy_link_tracker.sv
module phy_link_tracker (
  input  logic clk,
  input  logic rst,
  input  logic link_up,
  input  logic resync,
  output logic evt_up,
  output logic evt_down
);
  logic link_prev;
  logic need_sync;
  logic fire;

  always_ff @(posedge clk) begin
    if (rst) begin
      link_prev <= 1'b0;
      need_sync <= 1'b1;
    end else begin
      link_prev <= link_up;
      need_sync <= resync;
    end
  end

  assign fire     = need_sync || (link_up != link_prev);
  assign evt_up   = fire && link_up;
  assign evt_down = fire && !link_up;
endmodule

// File: rtl/phy_reg_model.sv
module phy_reg_model
  import phy_mgmt_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             acc_valid,
  input  logic             acc_write,
  input  logic [IDX_W-1:0] acc_idx,
  input  logic [PHY_W-1:0] acc_wdata,
  input  logic             evt_up,
  input  logic             evt_down,
  output logic [PHY_W-1:0] rd_value,
  output logic             soft_rst
);
  logic [PHY_W-1:0]  ctl_r, stat_r, adv_r;
  logic [ISRC_W-1:0] imsk_r, isrc_r;
  logic [PHY_W-1:0]  ctl_n, stat_n, adv_n;
  logic [ISRC_W-1:0] imsk_n, isrc_n;
  logic              wr_hit, rd_isrc;

  assign wr_hit   = acc_valid && acc_write;
  assign rd_isrc  = acc_valid && !acc_write && (acc_idx == IX_ISRC);
  assign soft_rst = wr_hit && (acc_idx == IX_CTRL) && acc_wdata[SOFT_RST_BIT];

  always_comb begin
    ctl_n  = ctl_r;
    stat_n = stat_r;
    adv_n  = adv_r;
    imsk_n = imsk_r;
    isrc_n = isrc_r;
    if (wr_hit) begin
      case (acc_idx)
        IX_CTRL: begin
          ctl_n = acc_wdata & CTRL_WMASK;
          if (acc_wdata[AN_START_BIT]) stat_n = stat_n | AN_DONE;
        end
        IX_ADV:  adv_n  = (acc_wdata & ADV_WMASK) | ADV_FORCE;
        IX_IMSK: imsk_n = acc_wdata[ISRC_W-1:0];
        default: ;
      endcase
    end
    if (rd_isrc) isrc_n = '0;
    if (evt_up) begin
      stat_n = stat_n | LINK_STAT;
      isrc_n = isrc_n | SRC_UP;
    end
    if (evt_down) begin
      stat_n = stat_n & ~LINK_STAT;
      isrc_n = isrc_n | SRC_DOWN;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || soft_rst) begin
      ctl_r  <= CTRL_RST;
      stat_r <= STAT_RST;
      adv_r  <= ADV_RST;
      imsk_r <= '0;
      isrc_r <= '0;
    end else begin
      ctl_r  <= ctl_n;
      stat_r <= stat_n;
      adv_r  <= adv_n;
      imsk_r <= imsk_n;
      isrc_r <= isrc_n;
    end
  end

  always_comb begin
    case (acc_idx)
      IX_CTRL: rd_value = ctl_r;
      IX_STAT: rd_value = stat_r;
      IX_IDH:  rd_value = ID_HI;
      IX_IDL:  rd_value = ID_LO;
      IX_ADV:  rd_value = adv_r;
      IX_LPA:  rd_value = LPA_VAL;
      IX_EXP:  rd_value = EXP_VAL;
      IX_ISRC: rd_value = {{(PHY_W-ISRC_W){1'b0}}, isrc_r};
      IX_IMSK: rd_value = {{(PHY_W-ISRC_W){1'b0}}, imsk_r};
      default: rd_value = '0;
    endcase
  end

  // R6
  ctrl_mask_chk: assert property (@(posedge clk) disable iff (rst)
    (ctl_r & ~CTRL_WMASK) == '0);
  // R7
  adv_force_chk: assert property (@(posedge clk) disable iff (rst)
    adv_r[7] && ((adv_r & ~(ADV_WMASK | ADV_FORCE)) == '0 || adv_r == ADV_RST));
  // R9
  isrc_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_isrc && !evt_up && !evt_down) |=> (isrc_r == '0));
  // R10
  link_up_chk: assert property (@(posedge clk) disable iff (rst)
    (evt_up && !soft_rst) |=> (stat_r[2] && stat_r[5] && isrc_r[7] && isrc_r[6]));
  // R10
  link_down_chk: assert property (@(posedge clk) disable iff (rst)
    (evt_down && !soft_rst) |=> (!stat_r[2] && !stat_r[5] && isrc_r[4]));
endmodule

// File: rtl/phy_mgmt_regs.sv
module phy_mgmt_regs
  import phy_mgmt_pkg::*;
#(
  parameter int CMD_LATENCY = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bus_wr,
  input  logic             bus_sel,
  input  logic [REG_W-1:0] bus_wdata,
  input  logic [PHY_W-1:0] rd_value,
  output logic [REG_W-1:0] ctrl_q,
  output logic [REG_W-1:0] data_q,
  output logic             acc_valid,
  output logic             acc_write,
  output logic [IDX_W-1:0] acc_idx,
  output logic [PHY_W-1:0] acc_wdata
);
  localparam int CNT_W = $clog2(CMD_LATENCY + 1);

  logic [CNT_W-1:0] cnt;
  logic             pending;

  assign pending   = ctrl_q[WR_BIT] || ctrl_q[RD_BIT];
  assign acc_valid = pending && (cnt == '0);
  assign acc_write = ctrl_q[WR_BIT];
  assign acc_idx   = ctrl_q[IDX_LSB +: IDX_W];
  assign acc_wdata = data_q[PHY_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
      data_q <= '0;
      cnt    <= '0;
    end else if (pending) begin
      if (cnt == '0) begin
        ctrl_q[WR_BIT] <= 1'b0;
        ctrl_q[RD_BIT] <= 1'b0;
        if (!ctrl_q[WR_BIT]) data_q[REG_W-1:PHY_W] <= rd_value;
      end else begin
        cnt <= cnt - 1'b1;
      end
    end else if (bus_wr) begin
      if (!bus_sel) begin
        ctrl_q <= bus_wdata;
        cnt    <= CNT_W'(CMD_LATENCY - 1);
      end else begin
        data_q <= bus_wdata;
      end
    end
  end

  // R2
  cmd_done_chk: assert property (@(posedge clk) disable iff (rst)
    acc_valid |=> !(ctrl_q[WR_BIT] || ctrl_q[RD_BIT]));
  // R3
  busy_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (pending && !acc_valid) |=> ($stable(ctrl_q) && $stable(data_q)));
  // R4
  lo_keep_chk: assert property (@(posedge clk) disable iff (rst)
    acc_valid |=> (data_q[PHY_W-1:0] == $past(data_q[PHY_W-1:0])));
  // R11
  wr_prio_chk: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && acc_write) |=> $stable(data_q));
endmodule

// File: rtl/phy_mgmt_unit.sv
module phy_mgmt_unit
  import phy_mgmt_pkg::*;
#(
  parameter int CMD_LATENCY = 4
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        bus_wr,
  input  logic        bus_sel,
  input  logic [31:0] bus_wdata,
  input  logic        link_up,
  output logic [31:0] ctrl_q,
  output logic [31:0] data_q
);
  logic             acc_valid, acc_write, soft_rst, evt_up, evt_down;
  logic [IDX_W-1:0] acc_idx;
  logic [PHY_W-1:0] acc_wdata, rd_value;

  phy_mgmt_regs #(.CMD_LATENCY(CMD_LATENCY)) u_regs (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_sel(bus_sel),
    .bus_wdata(bus_wdata), .rd_value(rd_value), .ctrl_q(ctrl_q),
    .data_q(data_q), .acc_valid(acc_valid), .acc_write(acc_write),
    .acc_idx(acc_idx), .acc_wdata(acc_wdata)
  );

  phy_reg_model u_phy (
    .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_write(acc_write),
    .acc_idx(acc_idx), .acc_wdata(acc_wdata), .evt_up(evt_up),
    .evt_down(evt_down), .rd_value(rd_value), .soft_rst(soft_rst)
  );

  phy_link_tracker u_link (
    .clk(clk), .rst(rst), .link_up(link_up), .resync(soft_rst),
    .evt_up(evt_up), .evt_down(evt_down)
  );
endmodule

// File: tb/tb_phy_mgmt_unit.sv
module tb_phy_mgmt_unit;
  localparam int LAT = 4;
  localparam logic [31:0] RD = 32'h0400_0000;
  localparam logic [31:0] WR = 32'h0800_0000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bus_wr = 1'b0;
  logic bus_sel = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic link_up = 1'b0;
  logic [31:0] ctrl_q, data_q;

  int n_chk = 0;
  int n_fail = 0;
  logic [31:0] data_model = '0;
  logic [31:0] exp_q[$];
  string tag_q[$];
  bit rd_out = 1'b0;
  bit prev_pend = 1'b0;

  always #2 clk = ~clk;

  phy_mgmt_unit #(.CMD_LATENCY(LAT)) dut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_sel(bus_sel),
    .bus_wdata(bus_wdata), .link_up(link_up), .ctrl_q(ctrl_q), .data_q(data_q)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
    end
  endtask

  // scoreboard monitor: pops an expected read result when a read completes
  always @(negedge clk) begin
    if (!rst) begin
      if (prev_pend && !(ctrl_q[27] | ctrl_q[26]) && rd_out) begin
        logic [31:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(data_q == e, {t, "/R4"}, data_q, e);
        rd_out = 1'b0;
      end
      prev_pend = ctrl_q[27] | ctrl_q[26];
    end
  end

  task automatic bus_write(input logic sel, input logic [31:0] v);
    bus_wr = 1'b1; bus_sel = sel; bus_wdata = v;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic wait_idle(output int n);
    n = 0;
    while (ctrl_q[27] | ctrl_q[26]) begin
      n++;
      @(negedge clk);
    end
    @(negedge clk);
  endtask

  task automatic phy_rd(input int idx, input logic [15:0] v, input string tag);
    int n;
    data_model[31:16] = v;
    exp_q.push_back(data_model);
    tag_q.push_back(tag);
    rd_out = 1'b1;
    bus_write(1'b0, RD | (32'(idx) << 21));
    wait_idle(n);
    chk(n == LAT, "R2 latency", n, LAT);
  endtask

  task automatic phy_wr(input int idx, input logic [31:0] v);
    int n;
    bus_write(1'b1, v);
    data_model = v;
    bus_write(1'b0, WR | (32'(idx) << 21));
    wait_idle(n);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk(ctrl_q == 32'h0, "R1 ctrl", ctrl_q, 32'h0);
    chk(data_q == 32'h0, "R1 data", data_q, 32'h0);
    repeat (3) @(negedge clk);

    // reset values, link down at start
    phy_rd(1, 16'h7809, "R5 status");
    phy_rd(0, 16'h3000, "R5 control");
    phy_rd(4, 16'h01E1, "R5 adv");
    phy_rd(30, 16'h0000, "R5 mask");
    phy_rd(29, 16'h0010, "R10 down at reset");
    phy_rd(29, 16'h0000, "R9 cleared");

    // constants and unimplemented
    phy_rd(2, 16'h0007, "R8 id hi");
    phy_rd(3, 16'hC0D1, "R8 id lo");
    phy_rd(5, 16'h0F71, "R8 lpa");
    phy_rd(6, 16'h0001, "R8 exp");
    phy_rd(7, 16'h0000, "R8 unimpl");

    // advertisement mask
    phy_wr(4, 32'h0000_FFFF);
    phy_rd(4, 16'h2DFF, "R7 all ones");
    phy_wr(4, 32'h0000_0000);
    phy_rd(4, 16'h0080, "R7 zero");

    // mask width
    phy_wr(30, 32'h0000_01FF);
    phy_rd(30, 16'h00FF, "R9 mask 8b");

    // control mask + autoneg
    phy_wr(0, 32'h0000_7FFF);
    phy_rd(0, 16'h7980, "R6 ctrl mask");
    phy_rd(1, 16'h7829, "R6 an done");

    // read-only status, ignored writes
    phy_wr(1, 32'h0000_0000);
    phy_rd(1, 16'h7829, "R8 status ro");
    phy_wr(7, 32'h0000_1234);
    phy_rd(7, 16'h0000, "R8 unimpl wr");

    // link up
    link_up = 1'b1;
    repeat (3) @(negedge clk);
    phy_rd(1, 16'h782D, "R10 up status");
    phy_rd(29, 16'h00C0, "R10 up src");
    phy_rd(29, 16'h0000, "R9 clear again");

    // link down clears bits 2 and 5
    link_up = 1'b0;
    repeat (3) @(negedge clk);
    phy_rd(1, 16'h7809, "R10 down status");
    phy_rd(29, 16'h0010, "R10 down src");

    // soft reset with link up re-applies link
    link_up = 1'b1;
    repeat (3) @(negedge clk);
    phy_rd(29, 16'h00C0, "R10 up again");
    phy_wr(0, 32'h0000_8000);
    repeat (2) @(negedge clk);
    phy_rd(0, 16'h3000, "R6 reset ctrl");
    phy_rd(4, 16'h01E1, "R6 reset adv");
    phy_rd(30, 16'h0000, "R6 reset mask");
    phy_rd(1, 16'h782D, "R6 reset status");
    phy_rd(29, 16'h00C0, "R6 relink src");

    // R3: writes ignored while pending
    bus_write(1'b1, 32'h0000_1111);
    data_model = 32'h0000_1111;
    data_model[31:16] = 16'h0007;
    exp_q.push_back(data_model);
    tag_q.push_back("R3 ignored");
    rd_out = 1'b1;
    bus_write(1'b0, RD | (32'd2 << 21));
    bus_write(1'b0, RD | (32'd3 << 21));
    bus_write(1'b1, 32'h2222_2222);
    wait_idle(n);
    chk(ctrl_q == (32'd2 << 21), "R3 ctrl kept", ctrl_q, 32'd2 << 21);

    // R11: both bits -> write, data untouched
    bus_write(1'b1, 32'h0000_0055);
    data_model = 32'h0000_0055;
    bus_write(1'b0, WR | RD | (32'd30 << 21));
    wait_idle(n);
    chk(data_q == 32'h0000_0055, "R11 data kept", data_q, 32'h0000_0055);
    chk(ctrl_q == (32'd30 << 21), "R2 bits cleared", ctrl_q, 32'd30 << 21);
    phy_rd(30, 16'h0055, "R11 wrote mask");

    chk(exp_q.size() == 0, "R4 scoreboard drained", exp_q.size(), 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule